// File: doc/BRIEF.md
# Triple Timer/Counter with Common Prescaler

This block holds three 16-bit timer/counter channels that share one programmable prescaler. In timer mode a channel advances on each prescaler tick; the tick comes once every (select + 1) system clocks, so a select of zero gives one advance per clock. In counter mode a channel advances once for each falling edge seen on its own external count pin. That pin is sampled on every system clock, and the prescaler does not slow this count.

Each channel runs either as a free-running 16-bit counter or as an 8-bit counter with auto-reload. In auto-reload mode the low byte counts, and when it rolls over it reloads from the high byte. Every rollover sets a sticky overflow flag. A plain write port loads a count, and a write always wins over an advance in the same cycle. A fourth sampled pin can capture the count of the last channel on its falling edge.

Each channel is controlled by a small state machine with three states. `CH_HALT` means the channel does not advance. `CH_TIMER` means it advances on prescaler ticks. `CH_COUNTER` means it advances on pin edges. From any state the machine moves on each clock:
- to `CH_HALT` when the run bit is low (transition *stop*);
- to `CH_TIMER` when the run bit is high and the mode bit is low (transition *start-timer*);
- to `CH_COUNTER` when both bits are high (transition *start-counter*).

So run and mode changes take effect one clock after they are sampled.

Top module: `tmr_trio`

## Requirements
- R1: After reset every count, every overflow flag and the capture register read zero, and the prescale select is zero.
- R2: With the prescale select at zero, a channel in `CH_TIMER` advances by one on every clock. The first advance lands on the second clock edge after its run bit goes high.
- R3: With prescale select N, every channel in `CH_TIMER` advances once every N+1 clocks, and all such channels advance on the same edge.
- R4: A write of the prescale select (`presc_wr` high) restarts the prescaler from zero, so the first advance after the write edge comes exactly N+1 clocks later.
- R5: A channel in `CH_COUNTER` (mode bit i = 1) advances by one for each sample pair where its pin went from 1 to 0. The advance is visible after the second clock edge following the first low sample. Rising edges, a steady level and the prescaler have no effect.
- R6: In 16-bit mode (`reload_mode` bit i = 0), an advance from 0xFFFF gives 0x0000 and sets overflow flag i.
- R7: In auto-reload mode (`reload_mode` bit i = 1), only bits [7:0] count. An advance from 0xFF in bits [7:0] loads bits [15:8] into bits [7:0], leaves bits [15:8] unchanged and sets overflow flag i.
- R8: An overflow flag stays set until `flag_clr` bit i is high at a clock edge. An overflow in that same cycle leaves the flag set.
- R9: `cnt_wr` with `cnt_sel` = i (0..2) loads `cnt_wdata` into channel i on that edge instead of any advance, and does not change the flag. A `cnt_sel` of 3 changes nothing.
- R10: A channel in `CH_HALT` keeps its count, apart from writes.
- R11: When `cap_en` is high, a falling edge on `pin_cap` copies the current count of channel 2 into `cap_val` on the second clock edge after the first low sample. When `cap_en` is low, `cap_val` is unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| presc_wr | input | 1 | Load the prescale select and restart the prescaler |
| presc_val | input | 4 | New prescale select value N (divide by N+1) |
| run | input | 3 | Per-channel run bits |
| ext_mode | input | 3 | Per-channel mode: 1 = count pin edges, 0 = count ticks |
| reload_mode | input | 3 | Per-channel mode: 1 = 8-bit auto-reload, 0 = 16-bit |
| cap_en | input | 1 | Enable capture of channel 2 on `pin_cap` falling edge |
| pin_cnt | input | 3 | External count pins, bit i for channel i |
| pin_cap | input | 1 | External capture pin |
| cnt_wr | input | 1 | Count write strobe |
| cnt_sel | input | 2 | Channel index for the write (3 = none) |
| cnt_wdata | input | 16 | Count value to load |
| flag_clr | input | 3 | Per-channel overflow flag clear |
| count | output | 48 | Counts, channel i in bits [16i+15:16i] |
| ovf | output | 3 | Sticky overflow flags |
| cap_val | output | 16 | Captured channel 2 count |

## Verification
The assertions check these rules on every cycle: the prescaler count stays within its select, a 16-bit wrap leads to zero with the flag set, an auto-reload rollover copies the high byte and keeps it, a set flag persists unless cleared, a write lands exactly, a halted channel holds still, capture takes the count of channel 2, and a detected pin edge never lasts two cycles. Some properties need a sequence of stimuli, and only the bench scenarios, backed by the per-clock reference model, show them. These are the exact spacing of advances after a select write, how many advances a burst of pin pulses gives, that rising edges and the prescaler leave a counter-mode channel alone, that a write to index 3 changes nothing, and that capture does nothing while it is disabled.

// File: rtl/tmr_pkg.sv
`timescale 1ns/1ps
package tmr_pkg;
    // Channel operating state: halted, ticking on the prescaler, or counting pin edges
    typedef enum logic [1:0] {
        CH_HALT    = 2'd0,
        CH_TIMER   = 2'd1,
        CH_COUNTER = 2'd2
    } ch_state_e;
endpackage

// File: rtl/tmr_prescaler.sv
`timescale 1ns/1ps
module tmr_prescaler #(
    parameter int PSW = 4
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           sel_wr,
    input  logic [PSW-1:0] sel_val,
    output logic           tick
);
    logic [PSW-1:0] sel_q;
    logic [PSW-1:0] phase_q;

    // A tick is issued on the last phase of each (select + 1)-clock period
    assign tick = (phase_q == sel_q);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sel_q   <= '0;
            phase_q <= '0;
        end else if (sel_wr) begin
            sel_q   <= sel_val;
            phase_q <= '0;
        end else if (tick) begin
            phase_q <= '0;
        end else begin
            phase_q <= phase_q + 1'b1;
        end
    end

    // R3: the phase never passes the select, so the period is select + 1
    assert_pc_bound_R3: assert property (@(posedge clk) disable iff (!rst_n)
        phase_q <= sel_q);
endmodule

// File: rtl/tmr_pin_edge.sv
`timescale 1ns/1ps
module tmr_pin_edge #(
    parameter int NP = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [NP-1:0] pins,
    output logic [NP-1:0] fall
);
    for (genvar g = 0; g < NP; g++) begin : g_pin
        logic samp_q;
        logic prev_q;

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                samp_q <= 1'b0;
                prev_q <= 1'b0;
            end else begin
                samp_q <= pins[g];
                prev_q <= samp_q;
            end
        end

        assign fall[g] = prev_q & ~samp_q;

        // R5: a detected edge lasts exactly one cycle
        assert_fall_single_R5: assert property (@(posedge clk) disable iff (!rst_n)
            fall[g] |=> !fall[g]);
    end
endmodule

// File: rtl/tmr_channel.sv
`timescale 1ns/1ps
module tmr_channel
    import tmr_pkg::*;
#(
    parameter int CW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          run,
    input  logic          ext_mode,
    input  logic          reload,
    input  logic          tick,
    input  logic          pin_fall,
    input  logic          wr,
    input  logic [CW-1:0] wdata,
    input  logic          clr,
    output logic [CW-1:0] cnt,
    output logic          flag
);
    localparam int HW = CW / 2;

    ch_state_e     state_q, state_d;
    logic          adv;
    logic          wrap;
    logic [CW-1:0] cnt_q, cnt_d;
    logic          flag_q, flag_d;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= CH_HALT;
        else        state_q <= state_d;
    end

    // Next state: stop, start-timer, start-counter
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            CH_HALT, CH_TIMER, CH_COUNTER: begin
                if (!run)          state_d = CH_HALT;
                else if (ext_mode) state_d = CH_COUNTER;
                else               state_d = CH_TIMER;
            end
            default: state_d = CH_HALT;
        endcase
    end

    // Outputs of the state machine: advance enable
    always_comb begin
        unique case (state_q)
            CH_HALT:    adv = 1'b0;
            CH_TIMER:   adv = tick;
            CH_COUNTER: adv = pin_fall;
            default:    adv = 1'b0;
        endcase
    end

    // Count datapath: a write wins over an advance
    always_comb begin
        cnt_d = cnt_q;
        wrap  = 1'b0;
        if (wr) begin
            cnt_d = wdata;
        end else if (adv) begin
            if (reload) begin
                if (cnt_q[HW-1:0] == '1) begin
                    cnt_d = {cnt_q[CW-1:HW], cnt_q[CW-1:HW]};
                    wrap  = 1'b1;
                end else begin
                    cnt_d = {cnt_q[CW-1:HW], cnt_q[HW-1:0] + 1'b1};
                end
            end else begin
                cnt_d = cnt_q + 1'b1;
                wrap  = (cnt_q == '1);
            end
        end
    end

    // Sticky flag: a set in the same cycle as a clear leaves it set
    always_comb begin
        if (wrap)     flag_d = 1'b1;
        else if (clr) flag_d = 1'b0;
        else          flag_d = flag_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q  <= '0;
            flag_q <= 1'b0;
        end else begin
            cnt_q  <= cnt_d;
            flag_q <= flag_d;
        end
    end

    assign cnt  = cnt_q;
    assign flag = flag_q;

    assert_wrap_zero_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (adv && !wr && !reload && cnt_q == '1) |=> (cnt_q == '0 && flag_q));

    assert_reload_copy_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (adv && !wr && reload && cnt_q[HW-1:0] == '1) |=>
            (cnt_q[HW-1:0] == $past(cnt_q[CW-1:HW]) && cnt_q[CW-1:HW] == $past(cnt_q[CW-1:HW]) && flag_q));

    assert_flag_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_q && !clr) |=> flag_q);

    assert_write_wins_R9: assert property (@(posedge clk) disable iff (!rst_n)
        wr |=> (cnt_q == $past(wdata)));

    assert_halt_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == CH_HALT && !wr) |=> $stable(cnt_q));
endmodule

// File: rtl/tmr_trio.sv
`timescale 1ns/1ps
module tmr_trio #(
    parameter int CW  = 16,
    parameter int NCH = 3,
    parameter int PSW = 4
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    presc_wr,
    input  logic [PSW-1:0]          presc_val,
    input  logic [NCH-1:0]          run,
    input  logic [NCH-1:0]          ext_mode,
    input  logic [NCH-1:0]          reload_mode,
    input  logic                    cap_en,
    input  logic [NCH-1:0]          pin_cnt,
    input  logic                    pin_cap,
    input  logic                    cnt_wr,
    input  logic [$clog2(NCH)-1:0]  cnt_sel,
    input  logic [CW-1:0]           cnt_wdata,
    input  logic [NCH-1:0]          flag_clr,
    output logic [NCH*CW-1:0]       count,
    output logic [NCH-1:0]          ovf,
    output logic [CW-1:0]           cap_val
);
    localparam int NP    = NCH + 1;
    localparam int SELW  = $clog2(NCH);
    localparam int CAPCH = NCH - 1;

    logic          tick;
    logic [NP-1:0] fall;
    logic [CW-1:0] cap_q;

    tmr_prescaler #(.PSW(PSW)) u_presc (
        .clk     (clk),
        .rst_n   (rst_n),
        .sel_wr  (presc_wr),
        .sel_val (presc_val),
        .tick    (tick)
    );

    tmr_pin_edge #(.NP(NP)) u_edge (
        .clk   (clk),
        .rst_n (rst_n),
        .pins  ({pin_cap, pin_cnt}),
        .fall  (fall)
    );

    for (genvar ch = 0; ch < NCH; ch++) begin : g_ch
        logic hit;
        assign hit = cnt_wr && (cnt_sel == SELW'(ch));

        tmr_channel #(.CW(CW)) u_ch (
            .clk      (clk),
            .rst_n    (rst_n),
            .run      (run[ch]),
            .ext_mode (ext_mode[ch]),
            .reload   (reload_mode[ch]),
            .tick     (tick),
            .pin_fall (fall[ch]),
            .wr       (hit),
            .wdata    (cnt_wdata),
            .clr      (flag_clr[ch]),
            .cnt      (count[ch*CW +: CW]),
            .flag     (ovf[ch])
        );
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                     cap_q <= '0;
        else if (cap_en && fall[NCH])   cap_q <= count[CAPCH*CW +: CW];
    end

    assign cap_val = cap_q;

    assert_capture_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (cap_en && fall[NCH]) |=> (cap_val == $past(count[CAPCH*CW +: CW])));
endmodule

// File: tb/sim_tmr_trio.sv
`timescale 1ns/1ps
module sim_tmr_trio;
    localparam int CW = 16, NCH = 3, PSW = 4;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic presc_wr = 1'b0;
    logic [3:0] presc_val = '0;
    logic [2:0] run = '0, ext_mode = '0, reload_mode = '0;
    logic cap_en = 1'b0;
    logic [2:0] pin_cnt = 3'b111;
    logic pin_cap = 1'b1;
    logic cnt_wr = 1'b0;
    logic [1:0] cnt_sel = '0;
    logic [15:0] cnt_wdata = '0;
    logic [2:0] flag_clr = '0;
    logic [47:0] count;
    logic [2:0] ovf;
    logic [15:0] cap_val;

    int n_chk = 0, n_err = 0;
    bit done = 0;

    tmr_trio #(.CW(CW), .NCH(NCH), .PSW(PSW)) u0 (
        .clk(clk), .rst_n(rst_n), .presc_wr(presc_wr), .presc_val(presc_val),
        .run(run), .ext_mode(ext_mode), .reload_mode(reload_mode), .cap_en(cap_en),
        .pin_cnt(pin_cnt), .pin_cap(pin_cap), .cnt_wr(cnt_wr), .cnt_sel(cnt_sel),
        .cnt_wdata(cnt_wdata), .flag_clr(flag_clr), .count(count), .ovf(ovf),
        .cap_val(cap_val)
    );

    always #2.5 clk = ~clk;

    task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    function automatic logic [15:0] cnt_of(int i);
        return count[i*16 +: 16];
    endfunction

    // Behavioural reference model, advanced on every clock
    int          m_pc, m_psel;
    logic [3:0]  m_samp, m_prev;
    int          m_st [3];
    logic [15:0] m_cnt [3];
    logic [2:0]  m_ovf;
    logic [15:0] m_cap;

    always @(posedge clk) begin : mdl
        logic tk;
        logic [3:0] fl;
        logic adv, setf;
        if (!rst_n) begin
            m_pc = 0; m_psel = 0; m_samp = '0; m_prev = '0;
            m_ovf = '0; m_cap = '0;
            for (int i = 0; i < 3; i++) begin m_st[i] = 0; m_cnt[i] = '0; end
        end else begin
            tk = (m_pc == m_psel);
            fl = m_prev & ~m_samp;
            if (cap_en && fl[3]) m_cap = m_cnt[2];
            for (int i = 0; i < 3; i++) begin
                adv  = (m_st[i] == 1 && tk) || (m_st[i] == 2 && fl[i]);
                setf = 1'b0;
                if (cnt_wr && int'(cnt_sel) == i) begin
                    m_cnt[i] = cnt_wdata;
                end else if (adv) begin
                    if (reload_mode[i]) begin
                        if (m_cnt[i][7:0] == 8'hFF) begin
                            m_cnt[i][7:0] = m_cnt[i][15:8];
                            setf = 1'b1;
                        end else begin
                            m_cnt[i][7:0] = m_cnt[i][7:0] + 8'd1;
                        end
                    end else begin
                        if (m_cnt[i] == 16'hFFFF) setf = 1'b1;
                        m_cnt[i] = m_cnt[i] + 16'd1;
                    end
                end
                if (setf)             m_ovf[i] = 1'b1;
                else if (flag_clr[i]) m_ovf[i] = 1'b0;
                m_st[i] = !run[i] ? 0 : (ext_mode[i] ? 2 : 1);
            end
            if (presc_wr) begin m_psel = int'(presc_val); m_pc = 0; end
            else if (tk) m_pc = 0;
            else         m_pc = m_pc + 1;
            m_prev = m_samp;
            m_samp = {pin_cap, pin_cnt};
        end
        #1;
        if (rst_n && !done) begin
            for (int i = 0; i < 3; i++) begin
                chk("R3 count vs model", 32'(cnt_of(i)), 32'(m_cnt[i]));
                chk("R8 flag vs model", 32'(ovf[i]), 32'(m_ovf[i]));
            end
            chk("R11 capture vs model", 32'(cap_val), 32'(m_cap));
        end
    end

    task automatic step(int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic wr(int ch, logic [15:0] d);
        cnt_wr = 1'b1; cnt_sel = 2'(ch); cnt_wdata = d;
        step(1);
        cnt_wr = 1'b0;
    endtask

    task automatic pwr(int v);
        presc_wr = 1'b1; presc_val = 4'(v);
        step(1);
        presc_wr = 1'b0;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    endtask

    initial begin
        #(5.0 * 150000);
        n_chk++; n_err++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        logic [15:0] c0, c1, c2;
        step(3);
        rst_n = 1'b1;
        #0.5;
        // R1 reset state
        chk("R1 count0", 32'(cnt_of(0)), 0);
        chk("R1 count2", 32'(cnt_of(2)), 0);
        chk("R1 flags", 32'(ovf), 0);
        chk("R1 capture", 32'(cap_val), 0);

        // R2 timer at select 0
        run = 3'b011;
        step(11);
        chk("R2 ch0 every clock", 32'(cnt_of(0)), 10);
        chk("R2 ch1 every clock", 32'(cnt_of(1)), 10);
        chk("R10 ch2 halted", 32'(cnt_of(2)), 0);

        // R4 / R3 select 11 restart and spacing
        pwr(11);
        c0 = cnt_of(0);
        step(11);
        chk("R4 no advance before N+1", 32'(cnt_of(0)), 32'(c0));
        step(1);
        chk("R4 first advance at N+1", 32'(cnt_of(0)), 32'(c0 + 16'd1));
        step(12);
        chk("R3 period N+1", 32'(cnt_of(0)), 32'(c0 + 16'd2));
        chk("R3 shared tick", 32'(cnt_of(1)), 32'(cnt_of(0)));

        // R5 counter mode on ch1
        ext_mode[1] = 1'b1;
        step(2);
        c1 = cnt_of(1);
        for (int k = 0; k < 5; k++) begin
            pin_cnt[1] = 1'b0; step(2);
            pin_cnt[1] = 1'b1; step(2);
        end
        step(3);
        chk("R5 five falling edges", 32'(cnt_of(1)), 32'(c1 + 16'd5));
        c1 = cnt_of(1);
        step(30);
        chk("R5 steady high and prescaler ignored", 32'(cnt_of(1)), 32'(c1));

        // R6 16-bit wrap
        pwr(0);
        wr(0, 16'hFFFD);
        step(3);
        chk("R6 wrap to zero", 32'(cnt_of(0)), 0);
        chk("R6 flag set", 32'(ovf[0]), 1);
        step(5);
        chk("R8 flag sticky", 32'(ovf[0]), 1);
        flag_clr[0] = 1'b1; step(1); flag_clr[0] = 1'b0;
        chk("R8 flag cleared", 32'(ovf[0]), 0);
        wr(0, 16'hFFFF);
        flag_clr[0] = 1'b1; step(1); flag_clr[0] = 1'b0;
        chk("R8 set beats clear", 32'(ovf[0]), 1);
        chk("R6 wrap value", 32'(cnt_of(0)), 0);

        // R9 write priority and ignored index
        wr(0, 16'h1234);
        chk("R9 write wins", 32'(cnt_of(0)), 32'h1234);
        chk("R9 flag unchanged by write", 32'(ovf[0]), 1);
        c0 = cnt_of(0); c1 = cnt_of(1); c2 = cnt_of(2);
        wr(3, 16'h0000);
        chk("R9 index 3 ignored ch0", 32'(cnt_of(0)), 32'(c0 + 16'd1));
        chk("R9 index 3 ignored ch1", 32'(cnt_of(1)), 32'(c1));
        chk("R9 index 3 ignored ch2", 32'(cnt_of(2)), 32'(c2));

        // R7 auto-reload on ch2
        run[2] = 1'b1; reload_mode[2] = 1'b1;
        step(2);
        wr(2, 16'h80FE);
        step(2);
        chk("R7 reload from high byte", 32'(cnt_of(2)), 32'h8080);
        chk("R7 flag set", 32'(ovf[2]), 1);
        step(1);
        chk("R7 counts on after reload", 32'(cnt_of(2)), 32'h8081);

        // R11 capture
        run[2] = 1'b0;
        step(2);
        wr(2, 16'h4242);
        cap_en = 1'b1; pin_cap = 1'b0;
        step(3);
        chk("R11 capture on falling edge", 32'(cap_val), 32'h4242);
        chk("R10 halted ch2 holds", 32'(cnt_of(2)), 32'h4242);
        pin_cap = 1'b1; cap_en = 1'b0;
        step(2);
        wr(2, 16'h1111);
        pin_cap = 1'b0;
        step(3);
        chk("R11 capture disabled", 32'(cap_val), 32'h4242);
        chk("R10 halted ch2 keeps write", 32'(cnt_of(2)), 32'h1111);

        // R10 stop ch0
        run[0] = 1'b0;
        step(2);
        c0 = cnt_of(0);
        step(10);
        chk("R10 stopped ch0 holds", 32'(cnt_of(0)), 32'(c0));

        step(2);
        finish_run();
    end
endmodule